// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synchronous static RAM meant to serve as the data store of a cache. Every address, control and chip-select input is captured on the rising clock edge. A small command set is decoded from those inputs: deselect, burst-read start, burst-write start, read continue, write continue and write continue with the beat masked. A two-bit beat counter produces four-beat bursts in interleaved order. The order is formed by XOR-ing the two low address bits of the start address with the beat number.

Writes are late: the data for a write beat is taken on the clock edge after the one that captured its command, and is written into the array on that edge. Reads pass through a synchronous array read and then an output register. Read data therefore appears two edges after the command edge, which is a read latency of three cycles counting the command cycle. The data path is split into equal groups that are stored in separate bank arrays. The output enable marks exactly the cycles that carry read data; in all other cycles the bus is meant to be at high impedance.

Top module: `sbr_burst_sram`

## Requirements
- R1: A burst starts only when `addr_stb_n` is 0 and the part is selected (`sel0_n`=0, `sel1`=1, `sel2_n`=0). When `addr_stb_n` is 0 and the part is not selected, the cycle is a deselect: nothing is read or written, and any open burst ends. Continue commands (`addr_stb_n`=1) ignore the select pins.
- R2: A read start (`addr_stb_n`=0, `wr_n`=1) captured on edge k puts the word at `addr` on `dq_o` after edge k+2, for one cycle.
- R3: A write start (`addr_stb_n`=0, `wr_n`=0) captured on edge k stores the `dq_i` value present at edge k+1 at `addr`.
- R4: While a burst is open, a continue (`addr_stb_n`=1, with `wr_n` matching the burst kind) accesses beats 2, 3 and 4. Each beat address is the start address with its two LSBs XOR-ed by the beat number 1, 2 or 3. For a start of 01 the order is 01, 00, 11, 10.
- R5: A write continue with `beat_mask`=1 advances the write burst by one beat and leaves that beat's word unchanged.
- R6: A continue is a deselect and changes no memory in three cases: no burst is open, the fourth beat is already done, or `wr_n` does not match the burst kind. In each case the burst ends.
- R7: A read start issued in the cycle right after a write start to the same address returns the newly written data.
- R8: `dq_oe` is 1 only in cycles that carry read data, and 0 in every other cycle.
- R9: The active-low asynchronous `rst_n` closes any burst and clears `dq_oe` at once. In-flight reads are dropped.
- R10: The array holds 2^`ADDR_W` words of `NGRP`×`GRP_W` bits. Every address keeps its own word, and all groups of the word are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Burst start address |
| addr_stb_n | input | 1 | Address strobe, active low: 0 starts a burst, 1 continues it |
| wr_n | input | 1 | 0 selects write, 1 selects read |
| beat_mask | input | 1 | Masks the current write-continue beat |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| dq_i | input | NGRP*GRP_W | Write data, taken one edge after its command |
| dq_o | output | NGRP*GRP_W | Read data from the output register |
| dq_oe | output | 1 | High in cycles where `dq_o` carries read data |

## Verification
Every start offset 0 to 3 is used for both write bursts and read bursts. Since every word holds distinct random data, a wrong interleave order shows up as a data mismatch rather than passing silently. Four kinds of continue are tried: masked continues, continues with no open burst, a fifth beat, and a continue of the wrong kind. Together these separate "advance without writing" from "do nothing". Each of the three ways of failing the select test is applied with a write start, and a read start is issued right after a write. A reset in the middle of a burst and a long mixed random stream cover the remaining orderings against a model of the burst and pipeline rules.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
   // operation carried by the registered beat stage
   typedef enum logic [1:0] {OP_NOP, OP_RD, OP_WR, OP_SKIP} beat_op_e;
   // kind of burst currently open
   typedef enum logic [1:0] {BS_IDLE, BS_RD, BS_WR} burst_st_e;
endpackage

// File: rtl/sbr_burst_ctl.sv
module sbr_burst_ctl
   import sbr_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_stb_n,
   input  logic              wr_n,
   input  logic              beat_mask,
   input  logic              sel_ok,
   input  logic [ADDR_W-1:0] addr_i,
   output beat_op_e          s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [1:0]        s1_beat
);
   localparam int HI_W = ADDR_W - 2;

   burst_st_e         st_q, st_d;
   logic [1:0]        cnt_q, cnt_d, nxt_cnt;
   logic [ADDR_W-1:0] base_q, base_d, addr_d;
   beat_op_e          op_d, op_q;
   logic [ADDR_W-1:0] addr_q;
   logic              start, cont_ok;

   assign nxt_cnt = cnt_q + 2'd1;
   assign start   = !addr_stb_n && sel_ok;
   assign cont_ok = addr_stb_n && (cnt_q != 2'd3) &&
                    ((st_q == BS_RD && wr_n) || (st_q == BS_WR && !wr_n));

   always_comb begin
      op_d   = OP_NOP;
      st_d   = BS_IDLE;
      cnt_d  = cnt_q;
      base_d = base_q;
      addr_d = addr_i;
      if (start) begin
         base_d = addr_i;
         cnt_d  = 2'd0;
         st_d   = wr_n ? BS_RD : BS_WR;
         op_d   = wr_n ? OP_RD : OP_WR;
      end else if (cont_ok) begin
         cnt_d  = nxt_cnt;
         st_d   = st_q;
         addr_d = {base_q[ADDR_W-1 -: HI_W], base_q[1:0] ^ nxt_cnt};
         if (st_q == BS_RD) op_d = OP_RD;
         else               op_d = beat_mask ? OP_SKIP : OP_WR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= BS_IDLE;
         cnt_q  <= 2'd0;
         base_q <= '0;
         op_q   <= OP_NOP;
         addr_q <= '0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         base_q <= base_d;
         op_q   <= op_d;
         addr_q <= addr_d;
      end
   end

   assign s1_op   = op_q;
   assign s1_addr = addr_q;
   assign s1_beat = cnt_q;
endmodule

// File: rtl/sbr_bank.sv
module sbr_bank #(
   parameter int ADDR_W = 10,
   parameter int W      = 18
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   output logic [W-1:0]      rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wdata;
      if (rd_en) rdata <= mem[addr];
   end
endmodule

// File: rtl/sbr_out_pipe.sv
module sbr_out_pipe #(
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_fire,
   input  logic [DW-1:0] rd_data,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe
);
   logic          vld_q, oe_q;
   logic [DW-1:0] out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         oe_q  <= 1'b0;
         out_q <= '0;
      end else begin
         vld_q <= rd_fire;
         oe_q  <= vld_q;
         out_q <= vld_q ? rd_data : '0;
      end
   end

   assign dq_o  = out_q;
   assign dq_oe = oe_q;
endmodule

// File: rtl/sbr_burst_sram.sv
module sbr_burst_sram
   import sbr_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int GRP_W  = 18,
   parameter int NGRP   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    addr_stb_n,
   input  logic                    wr_n,
   input  logic                    beat_mask,
   input  logic                    sel0_n,
   input  logic                    sel1,
   input  logic                    sel2_n,
   input  logic [NGRP*GRP_W-1:0]   dq_i,
   output logic [NGRP*GRP_W-1:0]   dq_o,
   output logic                    dq_oe
);
   localparam int DW = NGRP * GRP_W;

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 16) else $fatal(1, "ADDR_W out of range");
      assert (GRP_W >= 1)                  else $fatal(1, "GRP_W must be positive");
      assert (NGRP >= 1)                   else $fatal(1, "NGRP must be positive");
   end

   beat_op_e          s1_op;
   logic [ADDR_W-1:0] s1_addr;
   logic [1:0]        s1_beat;
   logic [DW-1:0]     rd_word;
   logic              sel_ok;

   assign sel_ok = !sel0_n && sel1 && !sel2_n;

   sbr_burst_ctl #(.ADDR_W(ADDR_W)) i_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_stb_n (addr_stb_n),
      .wr_n       (wr_n),
      .beat_mask  (beat_mask),
      .sel_ok     (sel_ok),
      .addr_i     (addr),
      .s1_op      (s1_op),
      .s1_addr    (s1_addr),
      .s1_beat    (s1_beat)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_bank
      sbr_bank #(.ADDR_W(ADDR_W), .W(GRP_W)) i_bank (
         .clk   (clk),
         .wr_en (s1_op == OP_WR),
         .rd_en (s1_op == OP_RD),
         .addr  (s1_addr),
         .wdata (dq_i[g*GRP_W +: GRP_W]),
         .rdata (rd_word[g*GRP_W +: GRP_W])
      );
   end

   sbr_out_pipe #(.DW(DW)) i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_fire (s1_op == OP_RD),
      .rd_data (rd_word),
      .dq_o    (dq_o),
      .dq_oe   (dq_oe)
   );
endmodule

// File: rtl/sbr_burst_sram_chk.sv
module sbr_burst_sram_chk
   import sbr_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input beat_op_e          s1_op,
   input logic [ADDR_W-1:0] s1_addr,
   input logic [1:0]        s1_beat,
   input logic              dq_oe
);
   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_op == OP_RD) |=> ##1 dq_oe); // R2

   AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $past(s1_op == OP_RD, 2)); // R8

   AST_BEAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_op != OP_NOP && s1_beat != 2'd0) |->
         ($past(s1_op) != OP_NOP && s1_beat == $past(s1_beat) + 2'd1)); // R4

   AST_BEAT_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_op != OP_NOP && s1_beat != 2'd0) |->
         (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]) &&
          s1_addr[1:0] != $past(s1_addr[1:0]))); // R4

   AST_BURST_KIND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_op == OP_RD && s1_beat != 2'd0) |-> ($past(s1_op) == OP_RD)); // R6

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (s1_op == OP_NOP && !dq_oe)); // R9
endmodule

bind sbr_burst_sram sbr_burst_sram_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .s1_op   (s1_op),
   .s1_addr (s1_addr),
   .s1_beat (s1_beat),
   .dq_oe   (dq_oe)
);

// File: tb/test_sbr_burst_sram.sv
module test_sbr_burst_sram;
   localparam int AW = 10;
   localparam int GW = 18;
   localparam int NG = 2;
   localparam int DW = GW * NG;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          addr_stb_n = 1'b1;
   logic          wr_n = 1'b1;
   logic          beat_mask = 1'b0;
   logic          sel0_n = 1'b1;
   logic          sel1 = 1'b0;
   logic          sel2_n = 1'b1;
   logic [DW-1:0] dq_i = '0;
   logic [DW-1:0] dq_o;
   logic          dq_oe;

   sbr_burst_sram #(.ADDR_W(AW), .GRP_W(GW), .NGRP(NG)) i_sbr_burst_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .addr_stb_n(addr_stb_n), .wr_n(wr_n),
      .beat_mask(beat_mask), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
      .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int failures = 0;
   string req_tag = "R9";

   // bench model of the requirements
   logic [DW-1:0] mdl [NW];
   int            m_st = 0;      // 0 idle, 1 read burst, 2 write burst
   int            m_cnt = 0;
   logic [AW-1:0] m_base = '0;
   int            p_op = 0;      // 0 none, 1 read, 2 write, 3 masked
   logic [AW-1:0] p_addr = '0;
   bit            r_v = 0, o_v = 0;
   logic [DW-1:0] r_d = '0, o_d = '0;
   int            selm = 0;

   function automatic logic [DW-1:0] rnd_d();
      return DW'({$urandom, $urandom});
   endfunction

   function automatic void model_edge();
      bit start, cont;
      o_v = r_v; o_d = r_d;
      r_v = (p_op == 1);
      if (p_op == 1) r_d = mdl[p_addr];
      if (p_op == 2) mdl[p_addr] = dq_i;
      start = !addr_stb_n && selm == 0;
      cont  = addr_stb_n && m_cnt != 3 &&
              ((m_st == 1 && wr_n) || (m_st == 2 && !wr_n));
      if (start) begin
         m_base = addr; m_cnt = 0; m_st = wr_n ? 1 : 2;
         p_op = m_st; p_addr = addr;
      end else if (cont) begin
         m_cnt++;
         p_addr = m_base ^ AW'(m_cnt);
         p_op = (m_st == 1) ? 1 : (beat_mask ? 3 : 2);
      end else begin
         m_st = 0; p_op = 0;
      end
   endfunction

   task automatic check_outputs();
      checks++;
      if (dq_oe !== o_v) begin
         failures++;
         $display("FAIL R8 (%s): dq_oe=%0b expected %0b at %0t", req_tag, dq_oe, o_v, $time);
      end
      if (o_v) begin
         checks++;
         if (dq_o !== o_d) begin
            failures++;
            $display("FAIL %s: dq_o=%h expected %h at %0t", req_tag, dq_o, o_d, $time);
         end
      end
   endtask

   task automatic apply_sel(input int m);
      selm = m;
      sel0_n = (m == 1); sel1 = (m != 2); sel2_n = (m == 3);
   endtask

   // one cycle: check current outputs, then drive inputs for the next edge
   task automatic step(input logic stb, input logic wr, input logic msk,
                       input int sm, input logic [AW-1:0] a, input logic [DW-1:0] wd);
      @(negedge clk);
      check_outputs();
      addr_stb_n = stb; wr_n = wr; beat_mask = msk; addr = a; dq_i = wd;
      apply_sel(sm);
      model_edge();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 1 + int'($urandom % 3), '0, rnd_d());
   endtask

   task automatic wr_burst(input logic [AW-1:0] a, input logic [3:0] msk);
      step(1'b0, 1'b0, 1'b0, 0, a, rnd_d());
      for (int k = 1; k < 4; k++) step(1'b1, 1'b0, msk[k], int'($urandom % 4), '0, rnd_d());
   endtask

   task automatic rd_burst(input logic [AW-1:0] a);
      step(1'b0, 1'b1, 1'b0, 0, a, rnd_d());
      for (int k = 1; k < 4; k++) step(1'b1, 1'b1, 1'b0, int'($urandom % 4), '0, rnd_d());
   endtask

   task automatic do_reset();
      @(negedge clk);
      check_outputs();
      rst_n = 1'b0;
      addr_stb_n = 1'b0; wr_n = 1'b1; beat_mask = 1'b0; apply_sel(1);
      #1;
      checks++;
      if (dq_oe !== 1'b0) begin
         failures++;
         $display("FAIL R9: dq_oe=%0b expected 0 during reset", dq_oe);
      end
      m_st = 0; m_cnt = 0; p_op = 0; r_v = 0; o_v = 0;
      @(negedge clk);
      check_outputs();
      rst_n = 1'b1;
      model_edge();
   endtask

   initial begin
      #1_500_000;
      failures++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0C0D));
      apply_sel(1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      req_tag = "R9";
      checks++;
      if (dq_oe !== 1'b0) begin
         failures++;
         $display("FAIL R9: dq_oe=%0b expected 0 after reset", dq_oe);
      end
      rst_n = 1'b1;

      // R3 / R10: fill the whole array with write bursts at every start offset
      req_tag = "R3";
      for (int b = 0; b < NW / 4; b++) wr_burst(AW'(b * 4 + (b % 4)), 4'b0000);
      idle(3);

      // R4 / R10: read bursts at each start offset, order shown by distinct data
      req_tag = "R4";
      for (int s = 0; s < 16; s++) rd_burst(AW'(($urandom % (NW / 4)) * 4 + (s % 4)));
      rd_burst(AW'(5));   // start 01 -> 01,00,11,10
      idle(3);
      req_tag = "R10";
      for (int b = 0; b < 32; b++) rd_burst(AW'(b * 32 + 3));
      idle(3);

      // R5: masked beats keep the old word
      req_tag = "R5";
      wr_burst(AW'(10'h042), 4'b1010);
      wr_burst(AW'(10'h083), 4'b1110);
      idle(2);
      rd_burst(AW'(10'h042));
      rd_burst(AW'(10'h083));
      idle(3);

      // R6: stray continues do nothing
      req_tag = "R6";
      step(1'b1, 1'b0, 1'b0, 0, '0, rnd_d());
      step(1'b1, 1'b1, 1'b0, 0, '0, rnd_d());
      wr_burst(AW'(10'h120), 4'b0000);
      step(1'b1, 1'b0, 1'b0, 0, '0, rnd_d());   // fifth beat
      step(1'b1, 1'b0, 1'b0, 0, '0, rnd_d());
      step(1'b0, 1'b0, 1'b0, 0, AW'(10'h131), rnd_d());
      step(1'b1, 1'b1, 1'b0, 0, '0, rnd_d());   // wrong kind
      step(1'b1, 1'b0, 1'b0, 0, '0, rnd_d());
      idle(2);
      rd_burst(AW'(10'h120));
      rd_burst(AW'(10'h130));
      step(1'b1, 1'b1, 1'b0, 0, '0, rnd_d());   // fifth read beat
      idle(3);

      // R1: each failed select pin turns a write start into a deselect
      req_tag = "R1";
      for (int m = 1; m < 4; m++) begin
         step(1'b0, 1'b0, 1'b0, m, AW'(10'h200 + m), rnd_d());
         step(1'b1, 1'b0, 1'b0, m, '0, rnd_d());
         idle(1);
         rd_burst(AW'(10'h200 + m));
         idle(3);
      end

      // R7: read right behind a write to the same word
      req_tag = "R7";
      for (int i = 0; i < 4; i++) begin
         step(1'b0, 1'b0, 1'b0, 0, AW'(10'h300 + i), rnd_d());
         step(1'b0, 1'b1, 1'b0, 0, AW'(10'h300 + i), rnd_d());
         idle(3);
      end

      // R9: reset in the middle of a read burst
      req_tag = "R9";
      step(1'b0, 1'b1, 1'b0, 0, AW'(10'h055), rnd_d());
      step(1'b1, 1'b1, 1'b0, 0, '0, rnd_d());
      do_reset();
      step(1'b1, 1'b1, 1'b0, 0, '0, rnd_d());
      step(1'b1, 1'b1, 1'b0, 0, '0, rnd_d());
      idle(3);

      // R2: mixed random traffic
      req_tag = "R2";
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         r = $urandom % 100;
         if (r < 22)      step(1'b0, 1'b1, 1'b0, 0, AW'($urandom), rnd_d());
         else if (r < 44) step(1'b0, 1'b0, 1'b0, 0, AW'($urandom), rnd_d());
         else if (r < 86) step(1'b1, 1'($urandom), 1'($urandom), int'($urandom % 4), AW'($urandom), rnd_d());
         else             step(1'b0, 1'($urandom), 1'b0, 1 + int'($urandom % 3), AW'($urandom), rnd_d());
      end
      idle(4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule